// File: doc/BRIEF.md
# Instruction Phase Ring With Step Bypass

This block generates the phase timing for a small sequential processor. It walks a single active phase through a fixed row of numbered steps, one clock per step, lowest index first. When the last enabled step is done it either starts over at step 0 or parks with no phase active. The datapath that uses each phase lies outside the block.

A bypass mask removes individual steps from the walk. One use is to drop a memory-wake step when the memory is already powered, or to drop a final write-back step. Step 0 can never be bypassed. A run level lets the ring restart freely. Lowering run mid-instruction never cuts the instruction short: the ring finishes the remaining enabled steps and then parks. While parked, a single-step pulse starts exactly one full instruction cycle. A one-clock completion flag marks the end of every instruction cycle.

Top module: `phase_ring`

## Requirements
- R1: In the clock after a cycle with `rst` high, `phase_oh` is all zero (parked) and `instr_done` is 0.
- R2: `phase_oh` never has more than one bit set; bit i set means step i is active.
- R3: Each active step lasts exactly one clock. The next phase is the lowest-indexed enabled step above the current one.
- R4: `bypass[i]` = 1 removes step i (i ≥ 1) from the walk. `bypass[0]` is ignored, so step 0 always runs.
- R5: While parked, `run` or `single_step` high at a clock edge makes step 0 (`phase_oh` = 1) active in the next clock.
- R6: When the last enabled step is active, `run` is sampled. If it is high, step 0 follows in the next clock. If it is low, the ring parks (all zero).
- R7: Dropping `run` while an instruction is in progress does not shorten it. Every remaining enabled step still runs before the ring parks.
- R8: `single_step` has no effect while a step is active. With `run` low, a single pulse while parked yields exactly one instruction cycle.
- R9: `instr_done` is high for one clock, the clock right after the last enabled step, whether the ring restarts or parks. It is low otherwise.
- R10: If every step above 0 is bypassed and `run` stays high, step 0 stays active and `instr_done` is high in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Free-run level; low parks the ring at the next wrap |
| single_step | input | 1 | Starts one instruction cycle while parked |
| bypass | input | STEPS | Per-step bypass mask; bit 0 ignored |
| phase_oh | output | STEPS | One-hot active step, all zero when parked |
| instr_done | output | 1 | One-clock flag after the final enabled step |

## Verification
A reference model of the walk is compared every clock while the bench mixes random bypass masks, random `run` toggles and sparse single-step pulses. These patterns separate the restart-or-park choice from a mid-instruction stop. Directed cases cover:
- an empty mask, which checks the plain in-order walk;
- a mask that drops steps 4 and 7, which shows that bypassed steps are never entered;
- an all-ones mask, which shows that bit 0 is ignored and that a one-step instruction signals completion every clock;
- a single-step pulse followed by a second pulse mid-instruction, which shows that exactly one cycle results.

// File: rtl/phase_ring_pkg.sv
package phase_ring_pkg;

    localparam int unsigned DEF_STEPS = 8;

    // Decision taken by the ring for the coming clock
    typedef struct packed {
        logic launch;   // parked -> step 0
        logic advance;  // move to next enabled step
        logic wrap;     // last step -> step 0
        logic park;     // last step -> parked
    } ring_dec_t;

    function automatic ring_dec_t decide(input logic parked, input logic at_end,
                                         input logic run, input logic single_step);
        ring_dec_t d;
        d.launch  = parked & (run | single_step);
        d.advance = ~parked & ~at_end;
        d.wrap    = ~parked & at_end & run;
        d.park    = ~parked & at_end & ~run;
        return d;
    endfunction

endpackage

// File: rtl/phase_enable_map.sv
module phase_enable_map #(
    parameter int unsigned STEPS = phase_ring_pkg::DEF_STEPS
) (
    input  logic [STEPS-1:0] bypass,
    output logic [STEPS-1:0] enabled
);
    // Step 0 is always part of the walk
    assign enabled[0] = 1'b1;
    generate
        for (genvar i = 1; i < STEPS; i++) begin : g_en
            assign enabled[i] = ~bypass[i];
        end
    endgenerate
endmodule

// File: rtl/phase_next_pick.sv
module phase_next_pick #(
    parameter int unsigned STEPS = phase_ring_pkg::DEF_STEPS
) (
    input  logic [STEPS-1:0] cur,
    input  logic [STEPS-1:0] enabled,
    output logic [STEPS-1:0] nxt,
    output logic             at_end
);
    // pend[j]: a token left some lower step and has not yet found an enabled step
    logic [STEPS:0] pend;
    assign pend[0] = 1'b0;
    generate
        for (genvar j = 0; j < STEPS; j++) begin : g_chain
            assign nxt[j]    = pend[j] & enabled[j];
            assign pend[j+1] = cur[j] | (pend[j] & ~enabled[j]);
        end
    endgenerate
    assign at_end = pend[STEPS];
endmodule

// File: rtl/phase_ring_core.sv
module phase_ring_core
    import phase_ring_pkg::*;
#(
    parameter int unsigned STEPS = DEF_STEPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             single_step,
    input  logic [STEPS-1:0] nxt,
    input  logic             at_end,
    output logic [STEPS-1:0] step_q,
    output logic             done_q
);
    localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

    logic             parked;
    ring_dec_t        dec;
    logic [STEPS-1:0] step_d;
    logic             done_d;

    assign parked = ~|step_q;
    assign dec    = decide(parked, at_end, run, single_step);

    always_comb begin
        step_d = '0;
        if (dec.launch || dec.wrap) step_d = FIRST;
        else if (dec.advance)       step_d = nxt;
        done_d = dec.wrap | dec.park;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            step_q <= step_d;
            done_q <= done_d;
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_q));

    a_r3_climbs: assert property (@(posedge clk) disable iff (rst)
        (!parked && !at_end) |=> (step_q > $past(step_q)));

    a_r5_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        parked |=> (step_q == '0 || step_q == FIRST));

    a_r6_park_on_stop: assert property (@(posedge clk) disable iff (rst)
        (!parked && at_end && !run) |=> (step_q == '0));

    a_r9_done_follows_step: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(step_q) != '0));
endmodule

// File: rtl/phase_ring.sv
module phase_ring
    import phase_ring_pkg::*;
#(
    parameter int unsigned STEPS = DEF_STEPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             single_step,
    input  logic [STEPS-1:0] bypass,
    output logic [STEPS-1:0] phase_oh,
    output logic             instr_done
);
    logic [STEPS-1:0] enabled;
    logic [STEPS-1:0] nxt;
    logic             at_end;

    phase_enable_map #(.STEPS(STEPS)) u_map (
        .bypass  (bypass),
        .enabled (enabled)
    );

    phase_next_pick #(.STEPS(STEPS)) u_pick (
        .cur     (phase_oh),
        .enabled (enabled),
        .nxt     (nxt),
        .at_end  (at_end)
    );

    phase_ring_core #(.STEPS(STEPS)) u_core (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .single_step (single_step),
        .nxt         (nxt),
        .at_end      (at_end),
        .step_q      (phase_oh),
        .done_q      (instr_done)
    );

    // A bypassed step above 0 is never entered
    a_r4_no_bypassed_entry: assert property (@(posedge clk) disable iff (rst)
        (phase_oh[STEPS-1:1] != '0) |-> ((phase_oh[STEPS-1:1] & $past(bypass[STEPS-1:1])) == '0));
endmodule

// File: tb/phase_ring_test.sv
module phase_ring_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         run;
    logic         single_step;
    logic [N-1:0] bypass;
    logic [N-1:0] phase_oh;
    logic         instr_done;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    cyc    = 0;
    bit    armed  = 0;
    string tag    = "R1";

    int    m_step;   // -1 parked
    logic  m_done;

    always #5 clk = ~clk;

    phase_ring #(.STEPS(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .single_step (single_step),
        .bypass      (bypass),
        .phase_oh    (phase_oh),
        .instr_done  (instr_done)
    );

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", t, act, exp, cyc);
        end
    endtask

    function automatic int find_next(input int cur, input logic [N-1:0] m);
        for (int j = cur + 1; j < N; j++)
            if (!m[j]) return j;
        return -1;
    endfunction

    function automatic logic [N-1:0] oh(input int s);
        logic [N-1:0] v = '0;
        if (s >= 0) v[s] = 1'b1;
        return v;
    endfunction

    // Reference model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_step <= -1;
            m_done <= 1'b0;
        end else if (m_step < 0) begin
            m_done <= 1'b0;
            if (run || single_step) m_step <= 0;
        end else begin
            int nx;
            nx = find_next(m_step, bypass);
            if (nx >= 0) begin
                m_step <= nx;
                m_done <= 1'b0;
            end else begin
                m_done <= 1'b1;
                m_step <= run ? 0 : -1;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed) check(tag, {23'd0, m_done, oh(m_step)}, {23'd0, instr_done, phase_oh});
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt;
        logic [N-1:0] seen;
        void'($urandom(32'd20230601));
        rst = 1'b1; run = 1'b0; single_step = 1'b0; bypass = '0;
        tick(3);
        check("R1 phase", {24'd0, phase_oh}, 32'd0);
        check("R1 done", {31'd0, instr_done}, 32'd0);
        armed = 1;
        rst = 1'b0;
        tick(3);
        check("R1 parked after reset", {24'd0, phase_oh}, 32'd0);

        // R5 / R3: free run, empty mask
        tag = "R3"; run = 1'b1;
        tick(1);
        check("R5 launch", {24'd0, phase_oh}, 32'd1);
        tick(20);

        // R7: stop mid-instruction
        tag = "R7";
        while (phase_oh != 8'h08) tick(1);
        run = 1'b0;
        for (int k = 4; k < N; k++) begin
            tick(1);
            check("R7 finishes", {24'd0, phase_oh}, 32'd1 << k);
        end
        tick(1);
        check("R7 parked", {24'd0, phase_oh}, 32'd0);
        check("R9 done at park", {31'd0, instr_done}, 32'd1);
        tick(1);
        check("R9 done one clock", {31'd0, instr_done}, 32'd0);

        // R8: single step, second pulse mid-instruction ignored
        tag = "R8"; tick(2);
        single_step = 1'b1;
        cnt = 0;
        for (int it = 0; it < 20; it++) begin
            tick(1);
            if (phase_oh[0]) cnt++;
            single_step = (it == 3);
        end
        single_step = 1'b0;
        check("R8 one cycle", cnt, 32'd1);
        check("R8 parked", {24'd0, phase_oh}, 32'd0);

        // R4: bypass steps 4 and 7
        tag = "R4"; bypass = 8'h90; run = 1'b1; seen = '0;
        for (int it = 0; it < 30; it++) begin
            tick(1);
            seen |= phase_oh;
        end
        check("R4 bypassed never active", {24'd0, seen & 8'h90}, 32'd0);
        check("R4 others active", {24'd0, seen}, 32'h6F);

        // R10 with bit 0 of the mask set (ignored, R4)
        tag = "R10"; bypass = 8'hFF;
        tick(3);
        for (int it = 0; it < 6; it++) begin
            tick(1);
            check("R10 step0 each clock", {24'd0, phase_oh}, 32'd1);
            check("R10 done each clock", {31'd0, instr_done}, 32'd1);
        end

        // R6: stop at wrap
        tag = "R6"; run = 1'b0;
        tick(2);
        for (int it = 0; it < 4; it++) begin
            tick(1);
            check("R6 stays parked", {24'd0, phase_oh}, 32'd0);
        end

        // Random mix
        for (int seg = 0; seg < 40; seg++) begin
            bypass = N'($urandom);
            for (int c = 0; c < 40; c++) begin
                if ($urandom % 8 == 0) run = ~run;
                single_step = ($urandom % 10 == 0);
                tick(1);
            end
        end
        single_step = 1'b0;
        tick(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule